// File: doc/BRIEF.md
# Luma Delay, Level Adjust and Sync Insertion Path

This block handles the luminance samples of a video encoder. Each sample carries two timing flags from the sync generator: a sync-tip flag and a blank flag. Sample and flags pass together through a fixed delay line. The delay line holds the luma back by the same number of clocks as the chroma path, so the two stay aligned. After the delay, a signed brightness offset is added and the sum is clamped. A programmable gain then scales the sample, and this result is clamped as well. Last, the sample is replaced by fixed DC levels whenever the flags ask for it.

The result is driven on two outputs. The S-video luma output gets no further delay. The composite luma output is the same stream held back by 0 to 3 extra pixel clocks. This offsets the different propagation times of baseband luma and modulated chroma further down the chip. A new extra-delay setting is only taken over on a line-start pulse, so the composite stream cannot jump part way through a line.

Top module: `luma_path`

## Requirements
- R1: The S-video luma output shows the processed result of an input sample exactly MATCH_DEPTH+3 clocks after the sample is presented (6+3 = 9 at default parameters).
- R2: Brightness adds the 8-bit two's-complement offset to the 10-bit luma. A sum above 1023 gives 1023 and a sum below 0 gives 0.
- R3: Gain multiplies the brightness result by the 8-bit unsigned gain and divides by 128. A gain of 128 is unity. A product above 1023 gives 1023.
- R4: While the sync-tip flag of a sample is set, its output is the sync-tip level, whatever the blank flag says.
- R5: While the blank flag is set and the sync-tip flag is clear, the output is the blank level.
- R6: A sample with neither flag set is never output below the black level. A smaller gain result is raised to the black level.
- R7: Mode select 0 uses the levels sync 16, blank 240, black 282. Mode select 1 uses sync 16, blank 252, black 252.
- R8: The composite output equals the S-video output delayed by the active extra-delay setting, 0 to 3 clocks.
- R9: The extra-delay select input is loaded into the active setting only in a cycle where line_start is high. It takes effect from the next clock. Changes at any other time have no effect on the composite output.
- R10: While rst_n is low at a clock edge, both outputs read 0 and the active extra delay returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| luma_in | input | 10 | Luma sample |
| sync_flag | input | 1 | Sample falls in a sync tip |
| blank_flag | input | 1 | Sample falls in a blanking interval |
| line_start | input | 1 | Line-start pulse; loads the extra-delay select |
| brt_offset | input | 8 | Signed brightness offset |
| gain | input | 8 | Luma gain, 128 = unity |
| pal_mode | input | 1 | Level set select (0 or 1) |
| xdly_sel | input | 2 | Requested extra composite delay in clocks |
| svid_luma | output | 10 | S-video luma stream |
| cvbs_luma | output | 10 | Composite luma stream |

## Verification
The S-video result of a sample is due nine clocks after the sample is driven. The composite result is due nine clocks plus the active extra delay. The bench keeps a history of every driven sample and, at each falling edge, compares the outputs against the model result of the sample driven that many cycles earlier. The brightness, gain and mode controls act on samples already inside the pipeline, so after any change to them the bench skips comparisons for the pipeline depth plus a margin. A new extra delay applies one clock after the line-start pulse, and the bench updates its composite offset in that same cycle.

// File: rtl/luma_pkg.sv
// Shared types and level constants for the luma path.
// Assumes 10-bit luma; levels are fixed per mode select.
package luma_pkg;
    localparam int Y_W    = 10;
    localparam int MAX_XD = 3;
    localparam int XD_W   = 2;

    typedef struct packed {
        logic [Y_W-1:0] y;
        logic           sync;
        logic           blank;
    } luma_smp_t;

    function automatic logic [Y_W-1:0] sync_level(input logic pal);
        return pal ? 10'd16 : 10'd16;
    endfunction

    function automatic logic [Y_W-1:0] blank_level(input logic pal);
        return pal ? 10'd252 : 10'd240;
    endfunction

    function automatic logic [Y_W-1:0] black_level(input logic pal);
        return pal ? 10'd252 : 10'd282;
    endfunction
endpackage

// File: rtl/luma_match_delay.sv
// Fixed delay line matching the chroma path latency.
// Sample and timing flags travel together; DEPTH must be at least 1.
module luma_match_delay
    import luma_pkg::*;
#(
    parameter int DEPTH = 6
) (
    input  logic      clk,
    input  logic      rst_n,
    input  luma_smp_t d_in,
    output luma_smp_t d_out
);
    luma_smp_t stage [DEPTH];

    genvar i;
    generate
        for (i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_first
                // Capture the incoming sample into the first stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[0] <= '0;
                    else        stage[0] <= d_in;
                end
            end else begin : g_next
                // Shift the sample one stage further.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[i] <= '0;
                    else        stage[i] <= stage[i-1];
                end
            end
        end
    endgenerate

    assign d_out = stage[DEPTH-1];
endmodule

// File: rtl/luma_adjust.sv
// Two-stage brightness and gain adjust.
// Stage 1 adds a signed offset with clamping to 0..1023.
// Stage 2 scales by gain / 2**GAIN_FRAC with clamping to 1023.
module luma_adjust
    import luma_pkg::*;
#(
    parameter int GAIN_W    = 8,
    parameter int GAIN_FRAC = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  luma_smp_t         d_in,
    input  logic [7:0]        brt_offset,
    input  logic [GAIN_W-1:0] gain,
    output luma_smp_t         d_out
);
    localparam int SUM_W  = Y_W + 2;
    localparam int PROD_W = Y_W + GAIN_W;
    localparam logic [Y_W-1:0] Y_MAX = '1;

    luma_smp_t          brt_q;
    luma_smp_t          gain_q;
    logic signed [SUM_W-1:0] sum;
    logic [Y_W-1:0]     brt_y;
    logic [PROD_W-1:0]  prod;
    logic [PROD_W-1:0]  scaled;
    logic [Y_W-1:0]     gain_y;

    // Signed add of the offset and clamp to the luma range.
    always_comb begin
        sum = $signed({2'b00, d_in.y}) + $signed({{(SUM_W-8){brt_offset[7]}}, brt_offset});
        if (sum[SUM_W-1])   brt_y = '0;
        else if (sum[Y_W])  brt_y = Y_MAX;
        else                brt_y = sum[Y_W-1:0];
    end

    // Register the brightness result with its flags.
    always_ff @(posedge clk) begin
        if (!rst_n) brt_q <= '0;
        else        brt_q <= '{y: brt_y, sync: d_in.sync, blank: d_in.blank};
    end

    // Multiply by gain, drop the fraction bits, clamp on overflow.
    always_comb begin
        prod   = {{GAIN_W{1'b0}}, brt_q.y} * {{Y_W{1'b0}}, gain};
        scaled = prod >> GAIN_FRAC;
        if (|scaled[PROD_W-1:Y_W]) gain_y = Y_MAX;
        else                       gain_y = scaled[Y_W-1:0];
    end

    // Register the gain result with its flags.
    always_ff @(posedge clk) begin
        if (!rst_n) gain_q <= '0;
        else        gain_q <= '{y: gain_y, sync: brt_q.sync, blank: brt_q.blank};
    end

    assign d_out = gain_q;

    p_brt_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (d_in.y == Y_MAX && !brt_offset[7]) |=> brt_q.y == Y_MAX);
    p_brt_bottom_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (d_in.y == '0 && brt_offset[7]) |=> brt_q.y == '0);
    p_gain_unity_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gain == GAIN_W'(1 << GAIN_FRAC)) |=> gain_q.y == $past(brt_q.y));
endmodule

// File: rtl/luma_sync_mux.sv
// Inserts the sync-tip and blank DC levels and floors active video at black.
// Sync has priority over blank. Output is registered.
module luma_sync_mux
    import luma_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  luma_smp_t      d_in,
    input  logic           pal_mode,
    output logic [Y_W-1:0] y_out
);
    logic [Y_W-1:0] sel_y;

    // Pick the level for this sample.
    always_comb begin
        if (d_in.sync)                          sel_y = sync_level(pal_mode);
        else if (d_in.blank)                    sel_y = blank_level(pal_mode);
        else if (d_in.y < black_level(pal_mode)) sel_y = black_level(pal_mode);
        else                                    sel_y = d_in.y;
    end

    // Register the selected level.
    always_ff @(posedge clk) begin
        if (!rst_n) y_out <= '0;
        else        y_out <= sel_y;
    end

    p_sync_tip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        d_in.sync |=> y_out == sync_level($past(pal_mode)));
    p_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!d_in.sync && d_in.blank) |=> y_out == blank_level($past(pal_mode)));
    p_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!d_in.sync && !d_in.blank) |=> y_out >= black_level($past(pal_mode)));
endmodule

// File: rtl/luma_comp_delay.sv
// Extra 0..MAX_XD clock delay for the composite branch.
// The select is taken over only on a line-start pulse.
module luma_comp_delay
    import luma_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [Y_W-1:0]  y_in,
    input  logic            line_start,
    input  logic [XD_W-1:0] xdly_sel,
    output logic [Y_W-1:0]  y_out
);
    logic [Y_W-1:0]  tap [MAX_XD];
    logic [XD_W-1:0] xd_q;

    // Load the active delay at line start only.
    always_ff @(posedge clk) begin
        if (!rst_n)          xd_q <= '0;
        else if (line_start) xd_q <= xdly_sel;
    end

    genvar i;
    generate
        for (i = 0; i < MAX_XD; i++) begin : g_tap
            // Shift the composite history by one clock.
            always_ff @(posedge clk) begin
                if (!rst_n) tap[i] <= '0;
                else        tap[i] <= (i == 0) ? y_in : tap[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    // Choose the undelayed stream or a history tap.
    always_comb begin
        if (xd_q == '0) y_out = y_in;
        else            y_out = tap[xd_q - 1'b1];
    end

    p_xd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> xd_q == $past(xd_q));
    p_cvbs_tap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (xd_q == XD_W'(1)) |-> y_out == $past(y_in));
endmodule

// File: rtl/luma_path.sv
// Luma path top: match delay, brightness and gain, sync insertion,
// then split into an S-video stream and a composite stream with extra delay.
// Assumes one sample per clock, with flags aligned to the sample.
module luma_path
    import luma_pkg::*;
#(
    parameter int MATCH_DEPTH = 6,
    parameter int GAIN_W      = 8,
    parameter int GAIN_FRAC   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [9:0]        luma_in,
    input  logic              sync_flag,
    input  logic              blank_flag,
    input  logic              line_start,
    input  logic [7:0]        brt_offset,
    input  logic [GAIN_W-1:0] gain,
    input  logic              pal_mode,
    input  logic [1:0]        xdly_sel,
    output logic [9:0]        svid_luma,
    output logic [9:0]        cvbs_luma
);
    luma_smp_t smp_in;
    luma_smp_t smp_dly;
    luma_smp_t smp_adj;
    logic [Y_W-1:0] mux_y;

    assign smp_in = '{y: luma_in, sync: sync_flag, blank: blank_flag};

    luma_match_delay #(.DEPTH(MATCH_DEPTH)) u_match (
        .clk(clk), .rst_n(rst_n), .d_in(smp_in), .d_out(smp_dly)
    );

    luma_adjust #(.GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)) u_adjust (
        .clk(clk), .rst_n(rst_n), .d_in(smp_dly),
        .brt_offset(brt_offset), .gain(gain), .d_out(smp_adj)
    );

    luma_sync_mux u_mux (
        .clk(clk), .rst_n(rst_n), .d_in(smp_adj),
        .pal_mode(pal_mode), .y_out(mux_y)
    );

    luma_comp_delay u_comp (
        .clk(clk), .rst_n(rst_n), .y_in(mux_y), .line_start(line_start),
        .xdly_sel(xdly_sel), .y_out(cvbs_luma)
    );

    assign svid_luma = mux_y;

    p_reset_zero_r10: assert property (@(posedge clk)
        !rst_n |=> (svid_luma == '0 && cvbs_luma == '0));
endmodule

// File: tb/luma_path_tb.sv
`timescale 1ns/1ps
module luma_path_tb;
    localparam int LAT = 9;
    localparam int HN  = 4096;

    logic clk = 0;
    logic rst_n = 0;
    logic [9:0] luma_in = '0;
    logic sync_flag = 0, blank_flag = 0, line_start = 0, pal_mode = 0;
    logic [7:0] brt_offset = '0, gain = 8'd128;
    logic [1:0] xdly_sel = '0;
    logic [9:0] svid_luma, cvbs_luma;

    int total = 0, bad = 0, cyc = 0, settle = 0, xd_m = 0;
    bit done = 0;
    logic [9:0] hy [HN];
    bit hs [HN];
    bit hb [HN];

    always #4 clk = ~clk;

    luma_path u_dut (
        .clk(clk), .rst_n(rst_n), .luma_in(luma_in), .sync_flag(sync_flag),
        .blank_flag(blank_flag), .line_start(line_start), .brt_offset(brt_offset),
        .gain(gain), .pal_mode(pal_mode), .xdly_sel(xdly_sel),
        .svid_luma(svid_luma), .cvbs_luma(cvbs_luma)
    );

    function automatic int model(input logic [9:0] y, input bit s, input bit b, output string tag);
        int v, p, blk;
        tag = "R1";
        v = int'(y) + int'($signed(brt_offset));
        if (v > 1023) begin v = 1023; tag = "R2"; end
        if (v < 0)    begin v = 0;    tag = "R2"; end
        p = (v * int'(gain)) >>> 7;
        if (p > 1023) begin p = 1023; tag = "R3"; end
        blk = pal_mode ? 252 : 282;
        if (s) begin tag = pal_mode ? "R7" : "R4"; return 16; end
        if (b) begin tag = pal_mode ? "R7" : "R5"; return pal_mode ? 252 : 240; end
        if (p < blk) begin p = blk; tag = pal_mode ? "R7" : "R6"; end
        return p;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s cyc=%0d actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    // One cycle: check outputs due now, then drive the next sample.
    task automatic tick(input logic [9:0] y, input bit s, input bit b, input bit ls, input string ctag);
        string tag;
        int e;
        @(negedge clk);
        if (settle == 0 && cyc >= LAT + 4) begin
            e = model(hy[(cyc-LAT)%HN], hs[(cyc-LAT)%HN], hb[(cyc-LAT)%HN], tag);
            check(tag, int'(svid_luma), e);
            e = model(hy[(cyc-LAT-xd_m)%HN], hs[(cyc-LAT-xd_m)%HN], hb[(cyc-LAT-xd_m)%HN], tag);
            check(ctag, int'(cvbs_luma), e);
        end
        luma_in = y; sync_flag = s; blank_flag = b; line_start = ls;
        if (ls) xd_m = int'(xdly_sel);
        hy[cyc%HN] = y; hs[cyc%HN] = s; hb[cyc%HN] = b;
        cyc++;
        if (settle > 0) settle--;
    endtask

    task automatic set_ctrl(input logic [7:0] bo, input logic [7:0] g, input bit pm);
        brt_offset = bo; gain = g; pal_mode = pm; settle = LAT + 4;
    endtask

    task automatic rand_run(input int n, input bit move_xd, input string ctag);
        for (int k = 0; k < n; k++) begin
            int r = $urandom_range(0, 99);
            bit ls = (k % 100 == 0);
            if (ls && move_xd) xdly_sel = 2'($urandom_range(0, 3));
            tick(10'($urandom_range(0, 1023)), r < 10, r >= 10 && r < 25, ls, ctag);
        end
    endtask

    initial begin
        void'($urandom(32'd24681));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10", int'(svid_luma), 0);
        check("R10", int'(cvbs_luma), 0);
        rst_n = 1;
        // random phases with random controls and extra delays
        for (int ph = 0; ph < 8; ph++) begin
            set_ctrl(8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)), ph[0]);
            rand_run(600, 1, "R8");
        end
        // directed: positive offset saturation at top
        set_ctrl(8'd127, 8'd128, 0);
        for (int k = 0; k < 60; k++) tick(10'd1000 + 10'(k % 24), 0, 0, 0, "R8");
        // directed: negative offset saturation at zero, floor at black
        set_ctrl(8'h80, 8'd128, 0);
        for (int k = 0; k < 60; k++) tick(10'(k), 0, 0, 0, "R8");
        // directed: gain overflow
        set_ctrl(8'd0, 8'd255, 1);
        for (int k = 0; k < 60; k++) tick(10'd900 + 10'(k), 0, 0, 0, "R8");
        // directed: zero gain gives black, sync over blank priority
        set_ctrl(8'd0, 8'd0, 0);
        for (int k = 0; k < 60; k++) tick(10'd500, k[0], 1, 0, "R8");
        // directed: select change without line start must be ignored
        set_ctrl(8'd0, 8'd128, 0);
        xdly_sel = 2'd2;
        tick(10'd300, 0, 0, 1, "R8");
        for (int k = 0; k < 40; k++) tick(10'd300 + 10'(k * 7), 0, 0, 0, "R8");
        xdly_sel = 2'd0;
        rand_run(99, 0, "R9");
        xdly_sel = 2'd3;
        for (int k = 0; k < 80; k++) tick(10'($urandom_range(0, 1023)), 0, 0, 0, "R9");
        tick(10'd400, 0, 0, 1, "R8");
        for (int k = 0; k < 80; k++) tick(10'($urandom_range(0, 1023)), 0, 0, 0, "R8");
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule